// File: doc/BRIEF.md
# Dual-Clock Cell FIFO

This block moves fixed-length cells from one clock domain to another. A writer in the write clock domain pushes one data word per enabled cycle and flags the last word of each cell with an end-of-cell strobe. A reader in the read clock domain pops one word per enabled cycle and flags the first word of each cell with a start-of-cell strobe. Word storage is a dual-port memory. Beside it, a cell counter tracks how many complete cells are stored, so the flags on both sides are defined in whole cells rather than in words.

The write side sees an almost-full flag. It is raised when the free space is smaller than one cell, so a writer that waits for the flag to drop can always finish the cell it starts. The read side sees a cell-available flag, which is raised when at least one finished cell is waiting. Word pointers and cell counts cross between the domains as Gray codes through two-flop synchronisers. Each flag is therefore computed from a delayed view of the other side, which can only make it cautious.

Word width is 8 bits, or 16 bits when `WIDE` is set. The cell length defaults to 53 words in narrow mode and 27 words in wide mode. Storage holds 2^`AW` words. Requests that break the flag rules are dropped and set a sticky error bit in the domain that made them.

Top module: `cell_fifo_dc`

## Requirements
- R1: While `rst_ni` is low and after its release, `afull_o`, `cell_avail_o`, `ovf_o` and `udf_o` are 0 and `rd_data_o` is 0.
- R2: Words are read out in the order they were written. `rd_data_o` takes the new word on the read clock edge that samples an accepted read, and it holds its value when no read is accepted.
- R3: `cell_avail_o` rises only after a word written with `wr_eoc_i`=1 completes a cell. A partly written cell never raises it.
- R4: An accepted read with `rd_soc_i`=1 removes one cell from the count. `cell_avail_o` drops right after the last counted cell is opened and stays high while further complete cells remain.
- R5: `afull_o` is 1 when the free words are fewer than one cell. With the defaults (256 words, 53-word cells), three stored cells give 0 and four give 1.
- R6: A write that would start a new cell while `afull_o`=1 is dropped and sets `ovf_o`. The dropped word is never read out.
- R7: A write that continues a cell already begun is accepted while `afull_o`=1, as long as storage is not completely full, and does not set `ovf_o`.
- R8: A read with `rd_soc_i`=1 while `cell_avail_o`=0 is dropped, even if a partial cell is stored. It sets `udf_o`, leaves `rd_data_o` unchanged and consumes no word.
- R9: A read with `rd_soc_i`=0 when no word is stored is dropped. It sets `udf_o` and leaves `rd_data_o` unchanged.
- R10: `ovf_o` and `udf_o` stay at 1 until `rst_ni` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_clk_i | input | 1 | Write domain clock |
| wr_en_i | input | 1 | Write one word this cycle |
| wr_eoc_i | input | 1 | Current write word ends a cell |
| wr_data_i | input | DW | Write data word |
| afull_o | output | 1 | Less than one cell of free space |
| ovf_o | output | 1 | Sticky: a write was dropped |
| rd_clk_i | input | 1 | Read domain clock |
| rd_en_i | input | 1 | Read one word this cycle |
| rd_soc_i | input | 1 | Current read word starts a cell |
| rd_data_o | output | DW | Read data, one cycle after the accepted read |
| cell_avail_o | output | 1 | At least one complete cell is stored |
| udf_o | output | 1 | Sticky: a read was dropped |

## Verification
The hardest state to reach from the ports is a new-cell write arriving while almost-full is high. Just before it, a cell that began below the threshold must be able to finish across the threshold. The stimulus fills three whole cells and then writes a fourth, which crosses the threshold partway through. It then offers one stray opening word. Draining everything and making one plain read from the empty store shows that the fourth cell was kept intact and the stray word was never stored. A second hard case is a start-of-cell read against a partly written cell. It is reached by writing part of a cell, letting the pointers settle, and then checking that the full cell later reads back from its first word.

// File: rtl/cell_fifo_pkg.sv
package cell_fifo_pkg;

  // default cell length in words for the chosen data width
  function automatic int cell_len(input bit wide);
    return wide ? 27 : 53;
  endfunction

endpackage

// File: rtl/cf_gray_sync.sv
module cf_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);
  end

endmodule

// File: rtl/cf_ram.sv
module cf_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/cf_wr_ctrl.sv
module cf_wr_ctrl #(
  parameter int AW         = 8,
  parameter int CELL_WORDS = 53,
  localparam int PW        = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_eoc_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wptr_gray_o,
  output logic [PW-1:0] wcell_gray_o,
  output logic          afull_o,
  output logic          ovf_o
);

  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] AF_LIM = PW'(DEPTH - CELL_WORDS);
  localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

  logic [PW-1:0] wptr_q, wcell_q, wptr_nx, wcell_nx, used;
  logic          open_q, ovf_q, accept, full;

  assign used    = wptr_q - rptr_bin_i;
  assign full    = (used == FULL_V);
  assign afull_o = (used > AF_LIM);
  // a cell already begun may finish past the threshold
  assign accept  = wr_en_i && (open_q ? !full : !afull_o);

  assign wptr_nx  = wptr_q + PW'(accept);
  assign wcell_nx = wcell_q + PW'(accept && wr_eoc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q       <= '0;
      wcell_q      <= '0;
      wptr_gray_o  <= '0;
      wcell_gray_o <= '0;
      open_q       <= 1'b0;
      ovf_q        <= 1'b0;
    end else begin
      wptr_q       <= wptr_nx;
      wcell_q      <= wcell_nx;
      wptr_gray_o  <= wptr_nx ^ (wptr_nx >> 1);
      wcell_gray_o <= wcell_nx ^ (wcell_nx >> 1);
      if (accept) open_q <= !wr_eoc_i;
      if (wr_en_i && !accept) ovf_q <= 1'b1;
    end
  end

  assign we_o    = accept;
  assign waddr_o = wptr_q[AW-1:0];
  assign ovf_o   = ovf_q;

  assert_new_cell_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !open_q && afull_o) |=> ($stable(wptr_q) && ovf_q));

  assert_no_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= FULL_V);

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/cf_rd_ctrl.sv
module cf_rd_ctrl #(
  parameter int AW  = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          rd_soc_i,
  input  logic [PW-1:0] wptr_bin_i,
  input  logic [PW-1:0] wcell_bin_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rptr_gray_o,
  output logic          cell_avail_o,
  output logic          udf_o
);

  logic [PW-1:0] rptr_q, rcell_q, rptr_nx;
  logic          udf_q, accept, nonempty;

  assign cell_avail_o = (wcell_bin_i != rcell_q);
  assign nonempty     = (wptr_bin_i != rptr_q);
  assign accept       = rd_en_i && (rd_soc_i ? cell_avail_o : nonempty);
  assign rptr_nx      = rptr_q + PW'(accept);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      rcell_q     <= '0;
      rptr_gray_o <= '0;
      udf_q       <= 1'b0;
    end else begin
      rptr_q      <= rptr_nx;
      rptr_gray_o <= rptr_nx ^ (rptr_nx >> 1);
      if (accept && rd_soc_i) rcell_q <= rcell_q + 1'b1;
      if (rd_en_i && !accept) udf_q <= 1'b1;
    end
  end

  assign re_o    = accept;
  assign raddr_o = rptr_q[AW-1:0];
  assign udf_o   = udf_q;

  assert_soc_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_soc_i && !cell_avail_o) |=> ($stable(rptr_q) && $stable(rcell_q) && udf_q));

  assert_empty_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_soc_i && !nonempty) |=> ($stable(rptr_q) && udf_q));

  assert_udf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_q |=> udf_q);

endmodule

// File: rtl/cell_fifo_dc.sv
module cell_fifo_dc
  import cell_fifo_pkg::*;
#(
  parameter bit WIDE       = 1'b0,
  parameter int DW         = WIDE ? 16 : 8,
  parameter int CELL_WORDS = cell_len(WIDE),
  parameter int AW         = 8
) (
  input  logic          rst_ni,
  input  logic          wr_clk_i,
  input  logic          wr_en_i,
  input  logic          wr_eoc_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          afull_o,
  output logic          ovf_o,
  input  logic          rd_clk_i,
  input  logic          rd_en_i,
  input  logic          rd_soc_i,
  output logic [DW-1:0] rd_data_o,
  output logic          cell_avail_o,
  output logic          udf_o
);

  localparam int PW = AW + 1;

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr_gray, wcell_gray, rptr_gray;
  logic [PW-1:0] rptr_bin_w, wptr_bin_r, wcell_bin_r;

  cf_wr_ctrl #(.AW(AW), .CELL_WORDS(CELL_WORDS)) u_wr (
    .clk_i        (wr_clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_eoc_i     (wr_eoc_i),
    .rptr_bin_i   (rptr_bin_w),
    .we_o         (we),
    .waddr_o      (waddr),
    .wptr_gray_o  (wptr_gray),
    .wcell_gray_o (wcell_gray),
    .afull_o      (afull_o),
    .ovf_o        (ovf_o)
  );

  cf_rd_ctrl #(.AW(AW)) u_rd (
    .clk_i        (rd_clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .rd_soc_i     (rd_soc_i),
    .wptr_bin_i   (wptr_bin_r),
    .wcell_bin_i  (wcell_bin_r),
    .re_o         (re),
    .raddr_o      (raddr),
    .rptr_gray_o  (rptr_gray),
    .cell_avail_o (cell_avail_o),
    .udf_o        (udf_o)
  );

  cf_gray_sync #(.W(PW)) u_sync_rptr (
    .clk_i (wr_clk_i), .rst_ni (rst_ni), .gray_i (rptr_gray), .bin_o (rptr_bin_w)
  );

  cf_gray_sync #(.W(PW)) u_sync_wptr (
    .clk_i (rd_clk_i), .rst_ni (rst_ni), .gray_i (wptr_gray), .bin_o (wptr_bin_r)
  );

  cf_gray_sync #(.W(PW)) u_sync_wcell (
    .clk_i (rd_clk_i), .rst_ni (rst_ni), .gray_i (wcell_gray), .bin_o (wcell_bin_r)
  );

  cf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i  (wr_clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .rclk_i  (rd_clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );

endmodule

// File: tb/tb_cell_fifo_dc.sv
module tb_cell_fifo_dc;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DW        = 8;
  localparam int CELL      = 53;
  localparam int AW        = 8;

  logic          rst_ni = 1'b0;
  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_en = 1'b0, wr_eoc = 1'b0, rd_en = 1'b0, rd_soc = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          afull, ovf, cell_avail, udf;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];

  always #(WR_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

  cell_fifo_dc #(.WIDE(1'b0), .AW(AW)) dut (
    .rst_ni       (rst_ni),
    .wr_clk_i     (wr_clk),
    .wr_en_i      (wr_en),
    .wr_eoc_i     (wr_eoc),
    .wr_data_i    (wr_data),
    .afull_o      (afull),
    .ovf_o        (ovf),
    .rd_clk_i     (rd_clk),
    .rd_en_i      (rd_en),
    .rd_soc_i     (rd_soc),
    .rd_data_o    (rd_data),
    .cell_avail_o (cell_avail),
    .udf_o        (udf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int id, input int i);
    return DW'(id * 37 + i * 5 + 3);
  endfunction

  task automatic wait_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic wait_wr(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic write_words(input int id, input int first, input int last,
                             input bit eoc_end, input bit push);
    for (int i = first; i <= last; i++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = pat(id, i);
      wr_eoc  = eoc_end && (i == last);
      if (push) exp_q.push_back(pat(id, i));
    end
    @(negedge wr_clk);
    wr_en  = 1'b0;
    wr_eoc = 1'b0;
  endtask

  task automatic read_word(input bit soc);
    @(negedge rd_clk);
    rd_en  = 1'b1;
    rd_soc = soc;
    @(negedge rd_clk);
    rd_en  = 1'b0;
    rd_soc = 1'b0;
  endtask

  // reads one cell; avail_after < 0 skips the flag check after the opening word
  task automatic read_cell(input string req, input int avail_after);
    logic [DW-1:0] e;
    for (int i = 0; i < CELL; i++) begin
      read_word(i == 0);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      chk(rd_data == e, req, int'(rd_data), int'(e));
      if (i == 0 && avail_after >= 0)
        chk(int'(cell_avail) == avail_after, "R4", int'(cell_avail), avail_after);
    end
  endtask

  task automatic t_reset();
    wr_en = 1'b0; wr_eoc = 1'b0; rd_en = 1'b0; rd_soc = 1'b0;
    rst_ni = 1'b0;
    exp_q.delete();
    wait_wr(3);
    chk(afull == 1'b0 && cell_avail == 1'b0, "R1", int'({afull, cell_avail}), 0);
    rst_ni = 1'b1;
    wait_rd(3);
    chk(afull == 1'b0, "R1", int'(afull), 0);
    chk(cell_avail == 1'b0, "R1", int'(cell_avail), 0);
    chk(ovf == 1'b0 && udf == 1'b0, "R1", int'({ovf, udf}), 0);
    chk(rd_data == '0, "R1", int'(rd_data), 0);
  endtask

  task automatic t_cell_build();
    logic [DW-1:0] keep;
    write_words(1, 0, CELL - 2, 1'b0, 1'b1);
    wait_rd(8);
    chk(cell_avail == 1'b0, "R3 partial cell", int'(cell_avail), 0);
    write_words(1, CELL - 1, CELL - 1, 1'b1, 1'b1);
    wait_rd(8);
    chk(cell_avail == 1'b1, "R3 complete cell", int'(cell_avail), 1);
    read_cell("R2 order", 0);
    keep = rd_data;
    wait_rd(4);
    chk(rd_data == keep, "R2 hold", int'(rd_data), int'(keep));
  endtask

  task automatic t_two_cells();
    write_words(2, 0, CELL - 1, 1'b1, 1'b1);
    write_words(3, 0, CELL - 1, 1'b1, 1'b1);
    wait_rd(8);
    chk(cell_avail == 1'b1, "R3", int'(cell_avail), 1);
    read_cell("R2 back-to-back", 1);
    read_cell("R2 back-to-back", 0);
  endtask

  task automatic t_early_soc();
    logic [DW-1:0] keep;
    write_words(4, 0, 9, 1'b0, 1'b1);
    wait_rd(8);
    keep = rd_data;
    read_word(1'b1);
    chk(udf == 1'b1, "R8 udf", int'(udf), 1);
    chk(rd_data == keep, "R8 data held", int'(rd_data), int'(keep));
    write_words(4, 10, CELL - 1, 1'b1, 1'b1);
    wait_rd(8);
    read_cell("R8 no word consumed", 0);
    wait_rd(5);
    chk(udf == 1'b1, "R10 udf sticky", int'(udf), 1);
    t_reset();
    chk(udf == 1'b0, "R10 udf cleared", int'(udf), 0);
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] keep;
    keep = rd_data;
    read_word(1'b0);
    chk(udf == 1'b1, "R9 udf", int'(udf), 1);
    chk(rd_data == keep, "R9 data held", int'(rd_data), int'(keep));
  endtask

  task automatic t_afull();
    logic [DW-1:0] keep;
    t_reset();
    for (int c = 0; c < 3; c++) write_words(10 + c, 0, CELL - 1, 1'b1, 1'b1);
    wait_wr(2);
    chk(afull == 1'b0, "R5 three cells", int'(afull), 0);
    write_words(13, 0, CELL - 1, 1'b1, 1'b1);
    wait_wr(2);
    chk(afull == 1'b1, "R5 four cells", int'(afull), 1);
    chk(ovf == 1'b0, "R7 open cell finished", int'(ovf), 0);
    write_words(99, 0, 0, 1'b0, 1'b0);
    chk(ovf == 1'b1, "R6 ovf", int'(ovf), 1);
    wait_rd(8);
    read_cell("R7 data", 1);
    read_cell("R7 data", 1);
    read_cell("R7 data", 1);
    read_cell("R7 data", 0);
    wait_wr(8);
    chk(afull == 1'b0, "R5 drained", int'(afull), 0);
    chk(cell_avail == 1'b0, "R6 no extra cell", int'(cell_avail), 0);
    keep = rd_data;
    read_word(1'b0);
    chk(rd_data == keep, "R6 stray word not stored", int'(rd_data), int'(keep));
    chk(udf == 1'b1, "R9 udf", int'(udf), 1);
    chk(ovf == 1'b1, "R10 ovf sticky", int'(ovf), 1);
    chk(exp_q.size() == 0, "R2 all read", exp_q.size(), 0);
    t_reset();
    chk(ovf == 1'b0, "R10 ovf cleared", int'(ovf), 0);
  endtask

  initial begin
    t_reset();
    t_cell_build();
    t_two_cells();
    t_early_soc();
    t_empty_read();
    t_afull();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule